// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer with Hold Arbitration

This block runs the external bus cycles of a small 8-bit processor. The core asks for a transfer by raising a request together with an address, write data, a direction bit and an address-space bit. It keeps these stable until the block answers with a one-clock done pulse. For a read, the data captured from the bus comes back with that pulse. On the bus side the block drives the address, the outgoing data, active-low read and write strobes and a space select. The space select tells memory transfers apart from I/O transfers. A slow device can stretch a transfer by holding the ready input low.

A second bus master can ask for the bus by raising hold. The block lets a transfer that has already started run to its end. It then raises the acknowledge output and stops driving every bus output. The core's requests wait while the bus belongs to the other master. When hold falls, the acknowledge falls on the next clock. The output enables come back half a clock after that, because they are registered on the falling clock edge.

The sequencer has five states. IDLE waits for work. ADDR presents the address for one clock. STROBE asserts the read or write strobe and repeats while ready is sampled low. DONE releases the strobe and pulses done. HELD is the state in which the bus is granted away. The transitions are:
- IDLE goes to HELD when hold is high, else to ADDR when a request is waiting.
- ADDR always goes to STROBE.
- STROBE goes to DONE when ready is high, else it stays in STROBE.
- DONE goes to HELD when hold is high, else to ADDR when a request is waiting, else to IDLE.
- HELD goes to IDLE when hold is low.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is active and after it, the block is in IDLE with `hlda` low, both strobes high, `req_done` low, `bus_dout_oe` low, and the address, strobe and select enables high, so the bus is driven to inactive levels.
- R2: A request accepted in IDLE gives one clock of address phase followed by the strobe phase. A read pulls only `bus_rd_n` low and a write pulls only `bus_wr_n` low. The two strobes are never low together.
- R3: The number of clocks with the strobe low equals one plus the number of clocks in which `ready` was sampled low during the strobe phase. `req_done` follows only a clock in which `ready` was sampled high.
- R4: `bus_io_m` is 1 for an I/O-space transfer (`req_io`=1) and 0 for a memory transfer. It holds steady while the strobe is low.
- R5: `bus_addr` equals the requested address and holds steady while the strobe is low. During a write, `bus_dout` equals the write data and `bus_dout_oe` is high.
- R6: For a read, `req_rdata` shown with `req_done` equals the `bus_din` value present at the clock edge that ended the strobe.
- R7: `req_done` is high for exactly one clock per transfer.
- R8: A hold request that arrives during a transfer does not raise `hlda` before that transfer has ended with `req_done`.
- R9: While `hlda` is high, all five output enables are low from the falling edge after `hlda` rises.
- R10: After `hold` falls, `hlda` falls at the next clock. The enables return at the falling edge that follows.
- R11: While `hlda` is high, no strobe goes low and `req_done` stays low. A request waiting through the hold is served once the hold ends.
- R12: When `hold` and a request are both present in IDLE, the hold wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request for a transfer |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | DW | Read data, valid with req_done |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | External master asks for the bus |
| hlda | output | 1 | Hold acknowledge |
| bus_addr | output | AW | Address bus value |
| bus_addr_oe | output | 1 | Address bus enable |
| bus_dout | output | DW | Outgoing data value |
| bus_dout_oe | output | 1 | Data bus enable |
| bus_din | input | DW | Incoming data |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_rd_oe | output | 1 | Read strobe enable |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wr_oe | output | 1 | Write strobe enable |
| bus_io_m | output | 1 | Space select, 1 = I/O |
| bus_iom_oe | output | 1 | Space select enable |

## Verification
The properties assume two things about the inputs. First, the core keeps its request fields steady from the moment it raises `req_valid` until it sees `req_done`. Second, `ready`, `hold` and `bus_din` are synchronous to the clock. The stimulus keeps within this by changing every input just after a falling edge, well away from the rising edge that samples it. A request is withdrawn only in the clock where done is observed. The random ready pattern has a cap on the number of wait states, so every transfer ends.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_DONE,
        ST_HELD
    } bcc_state_e;
endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    input  logic       hold,
    output bcc_state_e state,
    output logic       load
);
    bcc_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hold)           nxt = ST_HELD;
                else if (req_valid) nxt = ST_ADDR;
            end
            ST_ADDR:   nxt = ST_STROBE;
            ST_STROBE: if (ready) nxt = ST_DONE;
            ST_DONE: begin
                if (hold)           nxt = ST_HELD;
                else if (req_valid) nxt = ST_ADDR;
                else                nxt = ST_IDLE;
            end
            ST_HELD:   if (!hold) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // fields are captured on the way into the address phase
    assign load = (nxt == ST_ADDR);
endmodule

// File: rtl/bcc_latch.sv
module bcc_latch #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          cap_rd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          req_io,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_wdata,
    output logic          lat_write,
    output logic          lat_io,
    output logic [DW-1:0] lat_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_io    <= 1'b0;
        end else if (load) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
            lat_io    <= req_io;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_rdata <= '0;
        else if (cap_rd) lat_rdata <= bus_din;
    end
endmodule

// File: rtl/bcc_drive.sv
module bcc_drive
    import bcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bcc_state_e state,
    input  logic       lat_write,
    output logic       hlda,
    output logic       req_done,
    output logic       rd_n,
    output logic       wr_n,
    output logic       own_q,
    output logic       dout_oe
);
    // strobe, done and acknowledge levels decoded from the state
    always_comb begin
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        req_done = 1'b0;
        hlda     = 1'b0;
        unique case (state)
            ST_IDLE, ST_ADDR: ;
            ST_STROBE: begin
                rd_n = lat_write;
                wr_n = !lat_write;
            end
            ST_DONE: req_done = 1'b1;
            ST_HELD: hlda = 1'b1;
            default: ;
        endcase
    end

    // ownership flips half a clock after the acknowledge changes
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= 1'b1;
        else        own_q <= !hlda;
    end

    assign dout_oe = own_q && lat_write &&
                     (state == ST_ADDR || state == ST_STROBE || state == ST_DONE);
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          req_io,
    output logic          req_done,
    output logic [DW-1:0] req_rdata,
    input  logic          ready,
    input  logic          hold,
    output logic          hlda,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    input  logic [DW-1:0] bus_din,
    output logic          bus_rd_n,
    output logic          bus_rd_oe,
    output logic          bus_wr_n,
    output logic          bus_wr_oe,
    output logic          bus_io_m,
    output logic          bus_iom_oe
);
    bcc_state_e    state;
    logic          load;
    logic          cap_rd;
    logic          lat_write;
    logic          lat_io;
    logic          own_q;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;

    bcc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .hold      (hold),
        .state     (state),
        .load      (load)
    );

    assign cap_rd = (state == ST_STROBE) && ready && !lat_write;

    bcc_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cap_rd    (cap_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_io    (req_io),
        .bus_din   (bus_din),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .lat_write (lat_write),
        .lat_io    (lat_io),
        .lat_rdata (req_rdata)
    );

    bcc_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .lat_write (lat_write),
        .hlda      (hlda),
        .req_done  (req_done),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .own_q     (own_q),
        .dout_oe   (bus_dout_oe)
    );

    assign bus_addr    = lat_addr;
    assign bus_dout    = lat_wdata;
    assign bus_io_m    = lat_io;
    assign bus_addr_oe = own_q;
    assign bus_rd_oe   = own_q;
    assign bus_wr_oe   = own_q;
    assign bus_iom_oe  = own_q;
endmodule

// File: rtl/bus_cycle_ctrl_checks.sv
module bus_cycle_ctrl_checks #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic          req_done,
    input logic          hlda,
    input logic          bus_rd_n,
    input logic          bus_wr_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_io_m,
    input logic          bus_addr_oe,
    input logic          bus_dout_oe,
    input logic          bus_rd_oe,
    input logic          bus_wr_oe,
    input logic          bus_iom_oe
);
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n || bus_wr_n);

    p_done_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> ($past(ready) && !($past(bus_rd_n) && $past(bus_wr_n))));

    p_select_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> $stable(bus_io_m));

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> $stable(bus_addr));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    p_grant_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> ($past(bus_rd_n) && $past(bus_wr_n)));

    p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && $past(hlda)) |->
            !(bus_addr_oe || bus_dout_oe || bus_rd_oe || bus_wr_oe || bus_iom_oe));

    p_reclaim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hlda && !$past(hlda)) |->
            (bus_addr_oe && bus_rd_oe && bus_wr_oe && bus_iom_oe));

    p_quiet_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (bus_rd_n && bus_wr_n && !req_done));
endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_checks #(.AW(AW)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .req_done    (req_done),
    .hlda        (hlda),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_addr    (bus_addr),
    .bus_io_m    (bus_io_m),
    .bus_addr_oe (bus_addr_oe),
    .bus_dout_oe (bus_dout_oe),
    .bus_rd_oe   (bus_rd_oe),
    .bus_wr_oe   (bus_wr_oe),
    .bus_iom_oe  (bus_iom_oe)
);

// File: tb/bus_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_write = 1'b0;
    logic          req_io = 1'b0;
    logic          req_done;
    logic [DW-1:0] req_rdata;
    logic          ready = 1'b1;
    logic          hold = 1'b0;
    logic          hlda;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_oe;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_oe;
    logic [DW-1:0] bus_din = '0;
    logic          bus_rd_n;
    logic          bus_rd_oe;
    logic          bus_wr_n;
    logic          bus_wr_oe;
    logic          bus_io_m;
    logic          bus_iom_oe;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bus_cycle_ctrl #(.AW(AW), .DW(DW)) u_bus_cycle_ctrl (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [4:0] oe_vec();
        return {bus_addr_oe, bus_dout_oe, bus_rd_oe, bus_wr_oe, bus_iom_oe};
    endfunction

    function automatic int expect_low(input int waits);
        return waits + 1;
    endfunction

    // one transfer; optionally raises hold in the first strobe clock
    task automatic run_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit w, input bit io, input int max_wait,
                             input bit hold_mid);
        int waits = 0;
        int low = 0;
        int guard = 0;
        bit seen_done = 0;
        logic [DW-1:0] last_din = '0;
        req_valid = 1'b1; req_addr = a; req_wdata = d;
        req_write = w; req_io = io; ready = 1'b1;
        while (!seen_done && guard < 200) begin
            step();
            guard++;
            if (!bus_rd_n || !bus_wr_n) begin
                low++;
                chk(bus_rd_n == w && bus_wr_n == !w, "R2", "strobe kind",
                    {bus_rd_n, bus_wr_n}, {w, !w});
                chk(bus_addr == a, "R5", "address", bus_addr, a);
                chk(bus_io_m == io, "R4", "space select", bus_io_m, io);
                if (w) chk(bus_dout == d && bus_dout_oe, "R5", "write data",
                           {bus_dout_oe, bus_dout}, {1'b1, d});
                chk(!hlda, "R8", "hlda during transfer", hlda, 0);
                if (hold_mid && low == 1) hold = 1'b1;
                if (waits < max_wait && $urandom_range(0, 1) == 1) begin
                    ready = 1'b0;
                    waits++;
                end else begin
                    ready = 1'b1;
                end
                bus_din = DW'($urandom);
                last_din = bus_din;
            end else if (req_done) begin
                seen_done = 1;
                chk(low == expect_low(waits), "R3", "strobe clocks",
                    low, expect_low(waits));
                if (!w) chk(req_rdata == last_din, "R6", "read data",
                            req_rdata, last_din);
                req_valid = 1'b0;
                ready = 1'b1;
            end
        end
        chk(seen_done, "R2", "transfer finished", seen_done, 1);
        step();
        chk(!req_done, "R7", "done width", req_done, 0);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step();
        step();
        chk(!hlda && bus_rd_n && bus_wr_n && !req_done, "R1", "reset outputs",
            {hlda, bus_rd_n, bus_wr_n, req_done}, 4'b0110);
        chk(oe_vec() == 5'b10111, "R1", "reset enables", oe_vec(), 5'b10111);
        rst_n = 1'b1;
        step();
        chk(!hlda && bus_rd_n && bus_wr_n && !req_done, "R1", "idle after reset",
            {hlda, bus_rd_n, bus_wr_n, req_done}, 4'b0110);

        // directed: zero-wait read and write, both spaces
        run_cycle(16'h1234, 8'h00, 1'b0, 1'b0, 0, 1'b0);
        run_cycle(16'hbeef, 8'ha5, 1'b1, 1'b1, 0, 1'b0);
        // directed: long stretch
        run_cycle(16'h00ff, 8'h3c, 1'b0, 1'b1, 6, 1'b0);

        // hold raised mid-transfer
        run_cycle(16'h4444, 8'h77, 1'b1, 1'b0, 3, 1'b1);
        chk(hlda, "R8", "hlda after boundary", hlda, 1);
        chk(oe_vec() == 5'b0, "R9", "enables floated", oe_vec(), 0);
        req_valid = 1'b1; req_addr = 16'h5555; req_write = 1'b0; req_io = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(hlda && bus_rd_n && bus_wr_n && !req_done, "R11", "quiet while held",
                {hlda, bus_rd_n, bus_wr_n, req_done}, 4'b1110);
            chk(oe_vec() == 5'b0, "R9", "still floated", oe_vec(), 0);
        end
        hold = 1'b0;
        step();
        chk(!hlda, "R10", "hlda falls", hlda, 0);
        chk(oe_vec() == 5'b10111, "R10", "enables back", oe_vec(), 5'b10111);
        run_cycle(16'h5555, 8'h00, 1'b0, 1'b1, 2, 1'b0);

        // hold and request together in idle
        req_valid = 1'b1; req_addr = 16'h6666; req_write = 1'b1; req_io = 1'b0;
        req_wdata = 8'h99; hold = 1'b1;
        step();
        chk(hlda && bus_wr_n && bus_rd_n, "R12", "hold wins in idle",
            {hlda, bus_rd_n, bus_wr_n}, 3'b111);
        hold = 1'b0;
        step();
        run_cycle(16'h6666, 8'h99, 1'b1, 1'b0, 1, 1'b0);

        // random traffic
        for (int n = 0; n < 60; n++) begin
            run_cycle(AW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom),
                      $urandom_range(0, 5), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule